// File: doc/BRIEF.md
# Timekeeping Event Interrupt Controller

This block collects three event pulses from a real-time clock core and turns them into status flags and an interrupt request. The three events are a periodic tick, an alarm match and the end of each time update. Each pulse is one clock cycle long and sets its own sticky flag. The flag is set whether or not the source is enabled, so software may either take interrupts or poll the status register. An enable register holds one bit per source. Any flag that is set while its enable bit is also set drives the shared active-low interrupt line. The line is open-drain: its data value is always low and only its output enable changes.

A summary bit in the status register records that a request has been raised. A single accepted read of the status register returns the current flags and then clears all of them, the summary bit included, which releases the line. While the device runs from its backup supply, the register port is treated as unpowered and every access is ignored. The flag and request logic keeps running in that state, so an enabled alarm can still pull the line low to wake the host.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, all flags, the summary bit and all enable bits are 0, and the output enable `irq_oe_o` is 0.
- R2: An event pulse sets its flag at the next clock edge whatever the enable bits hold. Status bit positions: periodic = bit 0, alarm = bit 1, update-ended = bit 2, summary = bit DATA_W-1. All other bits read 0.
- R3: `irq_oe_o` is 1 in the cycle after an event whose enable bit is set. Enable bit positions match the status flag positions. A source that is not enabled never asserts `irq_oe_o`.
- R4: The summary bit becomes 1 at the same edge at which `irq_oe_o` becomes 1. It stays set until a status read, even if the enable bits are then cleared.
- R5: A status read (`bus_sel_i`=1, `bus_wr_i`=0, address STATUS_ADDR) returns the flags and summary in that same cycle. At the end of the cycle it clears all of them, and `irq_oe_o` returns to 0.
- R6: An event that arrives in the same cycle as a status read is not part of the returned value, and its flag is set after the read (together with the summary bit if that source is enabled).
- R7: A write to ENABLE_ADDR leaves the flags unchanged. Enabling a source whose flag is already set asserts `irq_oe_o` in the next cycle.
- R8: Clearing an enable bit drops `irq_oe_o` for that source in the next cycle, and the flag stays readable.
- R9: While `on_backup_i` is 1, reads return 0, writes are ignored and reads do not clear flags. An enabled alarm event still asserts `irq_oe_o`.
- R10: `irq_dat_o` is always 0.
- R11: A read of ENABLE_ADDR returns the enable bits in bits 2:0 and clears no flag.
- R12: An access to any other address reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| evt_periodic_i | input | 1 | Periodic tick pulse |
| evt_alarm_i | input | 1 | Alarm match pulse |
| evt_update_i | input | 1 | Update-ended pulse |
| on_backup_i | input | 1 | Running from the backup supply; the register port is dead |
| irq_oe_o | output | 1 | Output enable of the open-drain interrupt pin |
| irq_dat_o | output | 1 | Data value of the interrupt pin, always 0 |

## Verification
A flag that is lost, stuck or wrongly cleared shows up on the next status read as a wrong bit. If the source is enabled, it also shows up one cycle after the event as a wrong level on `irq_oe_o`. A summary bit that drifts from the request line is visible on any read taken while the line is low. A read-clear that wins over a coincident event shows up at once: the following status read returns 0 where the new flag should be. A gating fault in backup mode shows up either as a changed enable value after the supply returns or as a missing wake-up assertion.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int NUM_SRC = 3;
   localparam int SRC_PER = 0;
   localparam int SRC_ALM = 1;
   localparam int SRC_UPD = 2;

   typedef enum logic [1:0] {
      ACC_IDLE   = 2'd0,
      ACC_RD_EN  = 2'd1,
      ACC_WR_EN  = 2'd2,
      ACC_RD_ST  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   // a new event always wins over the clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (evt_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);  // R2
   AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !flag_o);  // R5
endmodule

// File: rtl/rtc_irq_bus_decode.sv
module rtc_irq_bus_decode
   import rtc_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int ENABLE_ADDR = 1,
   parameter int STATUS_ADDR = 2
) (
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              on_backup_i,
   output acc_kind_e         kind_o
);
   localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_ADDR);
   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);

   initial begin
      if (ENABLE_ADDR == STATUS_ADDR)
         $error("enable and status registers share one address");
      if (ENABLE_ADDR >= (1 << ADDR_W) || STATUS_ADDR >= (1 << ADDR_W))
         $error("register address does not fit ADDR_W");
   end

   always_comb begin
      kind_o = ACC_IDLE;
      if (bus_sel_i && !on_backup_i) begin
         if (bus_addr_i == EN_A)
            kind_o = bus_wr_i ? ACC_WR_EN : ACC_RD_EN;
         else if (bus_addr_i == ST_A && !bus_wr_i)
            kind_o = ACC_RD_ST;
      end
   end
endmodule

// File: rtl/rtc_irq_enable_reg.sv
module rtc_irq_enable_reg
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               on_backup_i,
   output logic [NUM_SRC-1:0] en_o,
   output logic [NUM_SRC-1:0] en_next_o
);
   logic [NUM_SRC-1:0] en_q;

   assign en_next_o = wr_i ? wdata_i[NUM_SRC-1:0] : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_next_o;
   end

   assign en_o = en_q;

   AST_BACKUP_HOLDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      on_backup_i |=> $stable(en_o));  // R9
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int ENABLE_ADDR = 1,
   parameter int STATUS_ADDR = 2,
   parameter bit RDATA_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              evt_periodic_i,
   input  logic              evt_alarm_i,
   input  logic              evt_update_i,
   input  logic              on_backup_i,
   output logic              irq_oe_o,
   output logic              irq_dat_o
);
   localparam int SUM_BIT = DATA_W - 1;

   initial begin
      if (DATA_W < NUM_SRC + 1)
         $error("DATA_W too small for flags plus summary bit");
      if (ADDR_W < 1)
         $error("ADDR_W must be at least 1");
   end

   acc_kind_e          kind;
   logic [NUM_SRC-1:0] evt;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] flags_next;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] en_next;
   logic               clr;
   logic               sum_q;
   logic [DATA_W-1:0]  rd_mux;

   always_comb begin
      evt          = '0;
      evt[SRC_PER] = evt_periodic_i;
      evt[SRC_ALM] = evt_alarm_i;
      evt[SRC_UPD] = evt_update_i;
   end

   rtc_irq_bus_decode #(
      .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR), .STATUS_ADDR(STATUS_ADDR)
   ) u_dec (
      .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .on_backup_i(on_backup_i), .kind_o(kind)
   );

   assign clr = (kind == ACC_RD_ST);

   rtc_irq_enable_reg #(.DATA_W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_i(kind == ACC_WR_EN),
      .wdata_i(bus_wdata_i), .on_backup_i(on_backup_i),
      .en_o(en_q), .en_next_o(en_next)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      rtc_irq_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n), .evt_i(evt[s]), .clr_i(clr), .flag_o(flags[s])
      );
      assign flags_next[s] = evt[s] | (flags[s] & ~clr);
   end

   // summary: sticky record of any raised request, aligned to the request line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= (sum_q & ~clr) | (|(flags_next & en_next));
   end

   assign irq_oe_o  = |(flags & en_q);
   assign irq_dat_o = 1'b0;

   always_comb begin
      rd_mux = '0;
      case (kind)
         ACC_RD_EN: rd_mux[NUM_SRC-1:0] = en_q;
         ACC_RD_ST: begin
            rd_mux[NUM_SRC-1:0] = flags;
            rd_mux[SUM_BIT]     = sum_q;
         end
         default: rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign bus_rdata_o = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata_o = rd_mux;
   end

   AST_REQUEST_HAS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe_o |-> sum_q);  // R4
   AST_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_WR_EN && evt == '0) |=> $stable(flags));  // R7
   AST_READ_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && evt == '0) |=> !irq_oe_o);  // R5
   AST_PIN_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_dat_o);  // R10
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam logic [AW-1:0] A_EN = 4'd1;
   localparam logic [AW-1:0] A_ST = 4'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic e_per = 1'b0, e_alm = 1'b0, e_upd = 1'b0;
   logic backup = 1'b0;
   logic oe, dat;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ENABLE_ADDR(1), .STATUS_ADDR(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_periodic_i(e_per),
      .evt_alarm_i(e_alm), .evt_update_i(e_upd), .on_backup_i(backup),
      .irq_oe_o(oe), .irq_dat_o(dat)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
      #1;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 1'b0;
      #1;
   endtask

   task automatic pulse(input logic [2:0] m);
      @(negedge clk); {e_upd, e_alm, e_per} = m;
      @(negedge clk); {e_upd, e_alm, e_per} = 3'b000;
      #1;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      chk("R1 oe after reset", oe, 0);
      bus_read(A_EN, d); chk("R1 enable after reset", d, 8'h00);
      bus_read(A_ST, d); chk("R1 status after reset", d, 8'h00);
      chk("R10 pin data", dat, 0);
   endtask

   task automatic t_poll();
      logic [DW-1:0] d;
      pulse(3'b001); chk("R3 disabled periodic no oe", oe, 0);
      pulse(3'b010); pulse(3'b100);
      chk("R3 disabled sources no oe", oe, 0);
      bus_read(A_ST, d); chk("R2 polled flags", d, 8'h07);
      bus_read(A_ST, d); chk("R5 flags cleared by read", d, 8'h00);
   endtask

   task automatic t_enabled();
      logic [DW-1:0] d;
      bus_write(A_EN, 8'h02);
      pulse(3'b001); chk("R3 periodic not enabled", oe, 0);
      bus_read(A_EN, d); chk("R11 enable readback", d, 8'h02);
      pulse(3'b010); chk("R3 alarm enabled asserts oe", oe, 1);
      chk("R10 pin data while active", dat, 0);
      bus_read(A_ST, d); chk("R4 summary with flags", d, 8'h83);
      chk("R5 oe released", oe, 0);
      bus_read(A_ST, d); chk("R5 all cleared", d, 8'h00);
   endtask

   task automatic t_coincide();
      logic [DW-1:0] d;
      bus_write(A_EN, 8'h07);
      pulse(3'b001);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = A_ST; e_upd = 1'b1;
      #1 d = rdata;
      @(negedge clk); sel = 1'b0; e_upd = 1'b0;
      #1;
      chk("R6 read returns old flags", d, 8'h81);
      chk("R6 new event keeps request", oe, 1);
      bus_read(A_ST, d); chk("R6 new flag survives read", d, 8'h84);
   endtask

   task automatic t_late_enable();
      logic [DW-1:0] d;
      bus_write(A_EN, 8'h00);
      pulse(3'b100); chk("R3 update disabled", oe, 0);
      bus_write(A_EN, 8'h04); chk("R7 late enable asserts oe", oe, 1);
      bus_write(A_EN, 8'h00); chk("R8 disable drops oe", oe, 0);
      bus_read(A_EN, d); chk("R11 enable read", d, 8'h00);
      bus_read(A_ST, d); chk("R4 R7 flag and summary kept", d, 8'h84);
   endtask

   task automatic t_backup();
      logic [DW-1:0] d;
      bus_write(A_EN, 8'h02);
      @(negedge clk); backup = 1'b1;
      bus_write(A_EN, 8'h00);
      bus_read(A_EN, d); chk("R9 read dead in backup", d, 8'h00);
      pulse(3'b010); chk("R9 alarm wakes in backup", oe, 1);
      bus_read(A_ST, d); chk("R9 status read dead", d, 8'h00);
      chk("R9 read did not clear", oe, 1);
      @(negedge clk); backup = 1'b0;
      bus_read(A_EN, d); chk("R9 write ignored in backup", d, 8'h02);
      bus_read(A_ST, d); chk("R9 alarm flag kept", d, 8'h82);
   endtask

   task automatic t_unused();
      logic [DW-1:0] d;
      pulse(3'b001);
      bus_write(4'd7, 8'hFF);
      bus_read(A_EN, d); chk("R12 stray write ignored", d, 8'h02);
      bus_read(4'd9, d); chk("R12 stray read zero", d, 8'h00);
      bus_read(A_ST, d); chk("R12 stray read kept flags", d, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_poll();
      t_enabled();
      t_coincide();
      t_late_enable();
      t_backup();
      t_unused();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule